// File: doc/BRIEF.md
# DRAM Channel Interleave Address Router

This block takes a physical system address and decides which of four DRAM controller channels owns it. It also produces the channel-local address that the channel's chip-select logic expects. The same request yields an error flag instead of a result when the address falls outside the programmed channel range, lands in the memory-mapped I/O hole below 4 GiB, or meets a configuration that is not legal.

Channel choice comes from a 4-bit interleave enable mask. An empty mask routes every address to a fixed channel. Two enabled channels split traffic on one address bit. Four enabled channels split it on two bits. The normalized address is formed in three steps. First a base is subtracted: either the range base, or the hole offset for addresses above 4 GiB when the legacy hole is enabled. Then the interleave bits are squeezed out. Finally an optional per-channel high offset is added.

Only channels 0 and 3 are physically present, so channel 3 is reported as index 1. A result appears one clock after the request strobe.

Top module: `chan_route_top`

## Requirements
- R1: When `ilv_mask` is 0, the channel is `direct_sel` and `ilv_mode` has no effect. A `direct_sel` above 3 raises the error flag.
- R2: The interleave way count is the number of set bits in `ilv_mask`. A count of 1 or 3 raises the error flag.
- R3: With a non-zero mask, `ilv_mode` 4 takes the select bits from address bit 8 upward, and `ilv_mode` 5 takes them from bit 9 upward. Any other mode value raises the error flag.
- R4: In two-way interleave, a select bit of 1 routes to channel 3 and a select bit of 0 routes to channel 0.
- R5: In four-way interleave, the two select bits (the lower address bit is the LSB) are the channel number.
- R6: The range base is `rng_base_fld` shifted left by 27. The inclusive limit is `rng_limit_fld` shifted left by 27, with bits 26:0 set to one. An address outside the range raises the error flag, and so does a request with `rng_valid` low.
- R7: With `hole_valid` set, an address at or above `hole_base` and below 2^32 raises the error flag.
- R8: When `legacy_hole_en` is set and the address is at or above 2^32, `hole_offset` is subtracted. Otherwise the range base is subtracted.
- R9: The interleave bits are removed by shifting the bits above them down over them. The low 8 bits (mode 4) or low 9 bits (mode 5) are kept unchanged. One bit is removed for two-way interleave and two bits for four-way. Nothing is removed with an empty mask.
- R10: When `hi_off_en` is set, the high offset of the selected channel is shifted left by 27 and added to the address. The selection uses the channel number before any renaming. Channel k's 12-bit high offset is `hi_off_flat[12k+11:12k]`.
- R11: Channel 3 appears on `out_chan` as 1. Channels 0, 1 and 2 appear as themselves.
- R12: Outputs are registered one cycle after `in_valid`. `out_valid` is `in_valid` without an error, and `out_err` is `in_valid` with an error. Both are low in reset and in every cycle after a cycle without `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| sys_addr | input | ADDR_W | System address |
| rng_valid | input | 1 | Channel range programmed |
| rng_base_fld | input | 13 | Range base, units of 2^27 |
| rng_limit_fld | input | 13 | Range limit, units of 2^27 |
| hole_valid | input | 1 | I/O hole active |
| hole_base | input | 32 | First byte address of the hole |
| hole_offset | input | ADDR_W | Offset subtracted above 4 GiB |
| legacy_hole_en | input | 1 | Use hole offset above 4 GiB |
| ilv_mode | input | 3 | Interleave position code (4 or 5) |
| ilv_mask | input | 4 | Interleave enable mask |
| direct_sel | input | 3 | Channel used when the mask is empty |
| hi_off_en | input | 1 | Add per-channel high offset |
| hi_off_flat | input | 48 | Four 12-bit high offsets, channel 0 lowest |
| out_valid | output | 1 | Routed result valid |
| out_err | output | 1 | Request rejected |
| out_chan | output | 2 | Reported channel index |
| out_addr | output | ADDR_W | Normalized channel address |

## Verification
A fault in the channel decode shows up on `out_chan` in the cycle after the request. A fault in the high-offset selection also shows up in that cycle, as a wrong `out_addr`. A fault in the bit squeeze or the base subtraction shows as `out_addr` values that are off by a power of two or by the range base. A misclassified request flips `out_valid` against `out_err`. Every fault becomes visible one clock after the strobe and never later, because no state lives beyond the output register.

// File: rtl/chan_route_pkg.sv
package chan_route_pkg;
  localparam int unsigned NUM_CH  = 4;
  localparam int unsigned CH_W    = $clog2(NUM_CH);
  localparam int unsigned FLD_W   = 13;
  localparam int unsigned HOFF_W  = 12;
  localparam int unsigned GRAN_SH = 27;
  localparam logic [2:0]  MODE_LO8 = 3'd4;
  localparam logic [2:0]  MODE_LO9 = 3'd5;

  // number of enabled interleave channels
  function automatic logic [2:0] pop4(input logic [3:0] m);
    logic [2:0] c;
    c = '0;
    for (int i = 0; i < 4; i++) c = c + {2'b0, m[i]};
    return c;
  endfunction

  // physical channel 3 is presented as index 1
  function automatic logic [CH_W-1:0] report_idx(input logic [CH_W-1:0] ch);
    return (ch == CH_W'(3)) ? CH_W'(1) : ch;
  endfunction
endpackage

// File: rtl/chan_route_sel.sv
module chan_route_sel
  import chan_route_pkg::*;
(
  input  logic [2:0]      sel_bits,   // address bits 10:8
  input  logic [3:0]      ilv_mask,
  input  logic [2:0]      ilv_mode,
  input  logic [2:0]      direct_sel,
  output logic [CH_W-1:0] chan,
  output logic [2:0]      ways,
  output logic            sel_err
);
  logic mode_ok;
  logic b_lo, b_hi;

  always_comb begin
    ways    = pop4(ilv_mask);
    mode_ok = (ilv_mode == MODE_LO8) || (ilv_mode == MODE_LO9);
    b_lo    = (ilv_mode == MODE_LO9) ? sel_bits[1] : sel_bits[0];
    b_hi    = (ilv_mode == MODE_LO9) ? sel_bits[2] : sel_bits[1];
    sel_err = 1'b0;
    chan    = '0;
    if (ways == 3'd0) begin
      chan    = direct_sel[CH_W-1:0];
      sel_err = (direct_sel > 3'd3);
    end else if (ways[0] || ways > 3'd4) begin
      sel_err = 1'b1;
    end else if (!mode_ok) begin
      sel_err = 1'b1;
    end else if (ways == 3'd2) begin
      chan = b_lo ? CH_W'(3) : CH_W'(0);
    end else begin
      chan = {b_hi, b_lo};
    end
  end
endmodule

// File: rtl/chan_route_norm.sv
module chan_route_norm
  import chan_route_pkg::*;
#(
  parameter int unsigned ADDR_W = 40
) (
  input  logic [ADDR_W-1:0]        sys_addr,
  input  logic                     rng_valid,
  input  logic [FLD_W-1:0]         rng_base_fld,
  input  logic [FLD_W-1:0]         rng_limit_fld,
  input  logic                     hole_valid,
  input  logic [31:0]              hole_base,
  input  logic [ADDR_W-1:0]        hole_offset,
  input  logic                     legacy_hole_en,
  input  logic [2:0]               ilv_mode,
  input  logic [2:0]               ways,
  input  logic [CH_W-1:0]          chan,
  input  logic                     hi_off_en,
  input  logic [NUM_CH*HOFF_W-1:0] hi_off_flat,
  output logic [ADDR_W-1:0]        norm_addr,
  output logic                     rng_err
);
  localparam logic [ADDR_W-1:0] FOUR_G   = ADDR_W'(1) << 32;
  localparam logic [ADDR_W-1:0] LOW_ONES = (ADDR_W'(1) << GRAN_SH) - ADDR_W'(1);

  // drop 'drop' bits at position 'lo', keeping bits below 'lo'
  function automatic logic [ADDR_W-1:0] squeeze(input logic [ADDR_W-1:0] a,
                                                input int lo, input int drop);
    logic [ADDR_W-1:0] keep;
    keep = (ADDR_W'(1) << lo) - ADDR_W'(1);
    return ((a >> (lo + drop)) << lo) | (a & keep);
  endfunction

  logic [HOFF_W-1:0] hoff [NUM_CH];
  for (genvar k = 0; k < NUM_CH; k++) begin : g_hoff
    assign hoff[k] = hi_off_flat[k*HOFF_W +: HOFF_W];
  end

  logic [ADDR_W-1:0] base_a, limit_a, sub_a, diff_a, sq_a, add_a;
  logic in_rng, hole_hit;
  int lo_n, drop_n;

  always_comb begin
    base_a   = ADDR_W'(rng_base_fld) << GRAN_SH;
    limit_a  = (ADDR_W'(rng_limit_fld) << GRAN_SH) | LOW_ONES;
    in_rng   = (sys_addr >= base_a) && (sys_addr <= limit_a);
    hole_hit = hole_valid && (sys_addr >= ADDR_W'(hole_base)) && (sys_addr < FOUR_G);
    rng_err  = !rng_valid || !in_rng || hole_hit;
    sub_a    = (legacy_hole_en && sys_addr >= FOUR_G) ? hole_offset : base_a;
    diff_a   = sys_addr - sub_a;
    lo_n     = (ilv_mode == MODE_LO9) ? 9 : 8;
    drop_n   = (ways == 3'd4) ? 2 : ((ways == 3'd2) ? 1 : 0);
    sq_a     = squeeze(diff_a, lo_n, drop_n);
    add_a    = hi_off_en ? (ADDR_W'(hoff[chan]) << GRAN_SH) : '0;
    norm_addr = sq_a + add_a;
  end
endmodule

// File: rtl/chan_route_top.sv
module chan_route_top
  import chan_route_pkg::*;
#(
  parameter int unsigned ADDR_W = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [ADDR_W-1:0]        sys_addr,
  input  logic                     rng_valid,
  input  logic [FLD_W-1:0]         rng_base_fld,
  input  logic [FLD_W-1:0]         rng_limit_fld,
  input  logic                     hole_valid,
  input  logic [31:0]              hole_base,
  input  logic [ADDR_W-1:0]        hole_offset,
  input  logic                     legacy_hole_en,
  input  logic [2:0]               ilv_mode,
  input  logic [3:0]               ilv_mask,
  input  logic [2:0]               direct_sel,
  input  logic                     hi_off_en,
  input  logic [NUM_CH*HOFF_W-1:0] hi_off_flat,
  output logic                     out_valid,
  output logic                     out_err,
  output logic [CH_W-1:0]          out_chan,
  output logic [ADDR_W-1:0]        out_addr
);
  localparam logic [ADDR_W-1:0] FOUR_G = ADDR_W'(1) << 32;

  logic [CH_W-1:0]   chan;
  logic [2:0]        ways;
  logic              sel_err, rng_err, req_err;
  logic [ADDR_W-1:0] norm_addr;

  chan_route_sel u_sel (
    .sel_bits  (sys_addr[10:8]),
    .ilv_mask  (ilv_mask),
    .ilv_mode  (ilv_mode),
    .direct_sel(direct_sel),
    .chan      (chan),
    .ways      (ways),
    .sel_err   (sel_err)
  );

  chan_route_norm #(.ADDR_W(ADDR_W)) u_norm (
    .sys_addr      (sys_addr),
    .rng_valid     (rng_valid),
    .rng_base_fld  (rng_base_fld),
    .rng_limit_fld (rng_limit_fld),
    .hole_valid    (hole_valid),
    .hole_base     (hole_base),
    .hole_offset   (hole_offset),
    .legacy_hole_en(legacy_hole_en),
    .ilv_mode      (ilv_mode),
    .ways          (ways),
    .chan          (chan),
    .hi_off_en     (hi_off_en),
    .hi_off_flat   (hi_off_flat),
    .norm_addr     (norm_addr),
    .rng_err       (rng_err)
  );

  assign req_err = sel_err | rng_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_chan  <= '0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid && !req_err;
      out_err   <= in_valid && req_err;
      if (in_valid) begin
        out_chan <= report_idx(chan);
        out_addr <= norm_addr;
      end
    end
  end

  // R12
  resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_err) |-> $past(in_valid));

  // R11
  rep_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_chan != CH_W'(3)));

  // R1
  direct_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ilv_mask == 4'd0 && direct_sel <= 3'd3 && !rng_err)
      |=> (out_valid && out_chan == report_idx($past(direct_sel[CH_W-1:0]))));

  // R2
  odd_ways_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ($countones(ilv_mask) == 1 || $countones(ilv_mask) == 3)) |=> out_err);

  // R4
  two_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $countones(ilv_mask) == 2 && ilv_mode == MODE_LO8 && !rng_err)
      |=> (out_valid && out_chan == ($past(sys_addr[8]) ? CH_W'(1) : CH_W'(0))));

  // R7
  hole_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hole_valid && sys_addr >= ADDR_W'(hole_base) && sys_addr < FOUR_G)
      |=> (out_err && !out_valid));
endmodule

// File: tb/chan_route_top_tb.sv
module chan_route_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 40;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [3:0]    mask;
    logic [2:0]    mode;
    logic [2:0]    dsel;
    logic          leg;
    logic          hoen;
    logic          err;
    logic [1:0]    chan;
    logic [AW-1:0] eaddr;
  } vec_t;

  // range 0x0800_0000..0x1_FFFF_FFFF, hole at 0xC000_0000, hole offset 0x4000_0000
  // high offsets: ch0=1, ch1=2, ch2=3, ch3=4 (units of 2^27)
  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{40'h00_0800_1234, 4'b0000, 3'd4, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 40'h00_0000_1234}, // R1 R8
    '{40'h00_0800_1234, 4'b0000, 3'd4, 3'd3, 1'b0, 1'b0, 1'b0, 2'd1, 40'h00_0000_1234}, // R1 R11
    '{40'h00_0800_0100, 4'b1001, 3'd4, 3'd0, 1'b0, 1'b0, 1'b0, 2'd1, 40'h00_0000_0000}, // R3 R4 R9
    '{40'h00_0800_0A55, 4'b1001, 3'd4, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 40'h00_0000_0555}, // R4 R9
    '{40'h00_0800_0300, 4'b1001, 3'd5, 3'd0, 1'b0, 1'b0, 1'b0, 2'd1, 40'h00_0000_0100}, // R3 R9
    '{40'h00_0800_0E34, 4'b1111, 3'd4, 3'd0, 1'b0, 1'b0, 1'b0, 2'd2, 40'h00_0000_0334}, // R5 R9
    '{40'h00_0800_0600, 4'b1111, 3'd5, 3'd0, 1'b0, 1'b0, 1'b0, 2'd1, 40'h00_0000_0000}, // R5 R11
    '{40'h00_0800_0100, 4'b1001, 3'd4, 3'd0, 1'b0, 1'b1, 1'b0, 2'd1, 40'h00_2000_0000}, // R10
    '{40'h01_0000_0000, 4'b0000, 3'd4, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 40'h00_C000_0000}, // R8
    '{40'h00_0900_0000, 4'b0000, 3'd4, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 40'h00_0100_0000}, // R8
    '{40'h00_C000_0000, 4'b0000, 3'd4, 3'd0, 1'b0, 1'b0, 1'b1, 2'd0, 40'h0},            // R7
    '{40'h00_0000_1000, 4'b0000, 3'd4, 3'd0, 1'b0, 1'b0, 1'b1, 2'd0, 40'h0},            // R6 below base
    '{40'h02_0000_0000, 4'b0000, 3'd4, 3'd0, 1'b0, 1'b0, 1'b1, 2'd0, 40'h0},            // R6 above limit
    '{40'h00_0800_0000, 4'b0001, 3'd4, 3'd0, 1'b0, 1'b0, 1'b1, 2'd0, 40'h0},            // R2 one way
    '{40'h00_0800_0000, 4'b0111, 3'd4, 3'd0, 1'b0, 1'b0, 1'b1, 2'd0, 40'h0},            // R2 three ways
    '{40'h00_0800_0000, 4'b1001, 3'd6, 3'd0, 1'b0, 1'b0, 1'b1, 2'd0, 40'h0},            // R3 bad mode
    '{40'h00_0800_0000, 4'b0000, 3'd4, 3'd5, 1'b0, 1'b0, 1'b1, 2'd0, 40'h0},            // R1 bad direct
    '{40'h01_FFFF_FFFF, 4'b0000, 3'd4, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 40'h01_F7FF_FFFF}, // R6 at limit
    '{40'h00_0800_0000, 4'b0000, 3'd4, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 40'h00_0000_0000}, // R6 at base
    '{40'h00_0800_0010, 4'b0000, 3'd7, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 40'h00_0000_0010}, // R1 mode ignored
    '{40'h00_0800_0000, 4'b0000, 3'd4, 3'd2, 1'b0, 1'b1, 1'b0, 2'd2, 40'h00_1800_0000}  // R10 ch2 offset
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [AW-1:0] sys_addr = '0;
  logic rng_valid = 1'b1;
  logic [12:0] rng_base_fld = 13'd1;
  logic [12:0] rng_limit_fld = 13'h3F;
  logic hole_valid = 1'b1;
  logic [31:0] hole_base = 32'hC000_0000;
  logic [AW-1:0] hole_offset = 40'h00_4000_0000;
  logic legacy_hole_en = 1'b0;
  logic [2:0] ilv_mode = 3'd4;
  logic [3:0] ilv_mask = 4'd0;
  logic [2:0] direct_sel = 3'd0;
  logic hi_off_en = 1'b0;
  logic [47:0] hi_off_flat = {12'd4, 12'd3, 12'd2, 12'd1};
  logic out_valid, out_err;
  logic [1:0] out_chan;
  logic [AW-1:0] out_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_route_top #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sys_addr(sys_addr),
    .rng_valid(rng_valid), .rng_base_fld(rng_base_fld), .rng_limit_fld(rng_limit_fld),
    .hole_valid(hole_valid), .hole_base(hole_base), .hole_offset(hole_offset),
    .legacy_hole_en(legacy_hole_en), .ilv_mode(ilv_mode), .ilv_mask(ilv_mask),
    .direct_sel(direct_sel), .hi_off_en(hi_off_en), .hi_off_flat(hi_off_flat),
    .out_valid(out_valid), .out_err(out_err), .out_chan(out_chan), .out_addr(out_addr)
  );

  task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, registered at the next rising edge, sample at the next falling edge
  task automatic issue(input vec_t v);
    @(negedge clk);
    sys_addr = v.addr; ilv_mask = v.mask; ilv_mode = v.mode; direct_sel = v.dsel;
    legacy_hole_en = v.leg; hi_off_en = v.hoen; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_eq("R12 reset out_valid", 64'(out_valid), 64'd0);
    check_eq("R12 reset out_err", 64'(out_err), 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i]);
      check_eq($sformatf("R12 vec %0d out_err", i), 64'(out_err), 64'(VECS[i].err));
      check_eq($sformatf("R12 vec %0d out_valid", i), 64'(out_valid), 64'(!VECS[i].err));
      if (!VECS[i].err) begin
        check_eq($sformatf("R11 vec %0d out_chan", i), 64'(out_chan), 64'(VECS[i].chan));
        check_eq($sformatf("R9 vec %0d out_addr", i), 64'(out_addr), 64'(VECS[i].eaddr));
      end
    end

    // R12: idle cycle after a request drops both flags
    @(negedge clk);
    check_eq("R12 idle out_valid", 64'(out_valid), 64'd0);
    check_eq("R12 idle out_err", 64'(out_err), 64'd0);

    // R6: unprogrammed range rejects an otherwise good address
    rng_valid = 1'b0;
    issue(VECS[0]);
    check_eq("R6 rng_valid low out_err", 64'(out_err), 64'd1);
    rng_valid = 1'b1;

    // R7: hole disabled lets the hole address through
    hole_valid = 1'b0;
    issue('{40'h00_C000_0000, 4'b0000, 3'd4, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 40'h0});
    check_eq("R7 hole off out_valid", 64'(out_valid), 64'd1);
    check_eq("R8 hole off out_addr", 64'(out_addr), 64'h00_B800_0000);
    hole_valid = 1'b1;

    // R10: channel 1 offset in four-way mode, select bits 9:8 = 01
    issue('{40'h00_0800_0100, 4'b1111, 3'd4, 3'd0, 1'b0, 1'b1, 1'b0, 2'd1, 40'h0});
    check_eq("R5 ch1 out_chan", 64'(out_chan), 64'd1);
    check_eq("R10 ch1 out_addr", 64'(out_addr), 64'h00_1000_0000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule